// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block runs the one-time bring-up of an SDRAM device after power is applied, before the memory controller may send normal accesses. A single `start` pulse makes it capture three configuration words (the timing word, the bank-group 0 word and the bank-group 1 word) together with an optional mode-data override. It then replays them to the controller's configuration registers and drives a timed series of SDRAM commands on a strobe-qualified command port.

The mode-register data is derived from the CAS latency held in the timing word and from the data-width bit of the group 0 word. A nonzero override replaces the derived value. The derived or override value sits above the two-bit command code in every command issued after the power-up wait. Auto-refresh is kept off for the whole run: the timing word is first written with its refresh field cleared, and the full word is written only after the mode-register set. Both waits are derived from a clock-frequency parameter. The sequencer then parks in its final state with `done` high until the next reset.

States, in order: IDLE (wait for `start`), GRP0 (write group 0 word), GRP1 (write group 1 word), TIM_SAFE (write timing word with refresh cleared), NOP (issue NOP, load power-up wait), PWR_WAIT (count down), ISSUE (issue one command, load gap wait), GAP (count down), TIM_FULL (write full timing word), DONE. Transitions: IDLE→GRP0 on `start`. GRP0→GRP1→TIM_SAFE→NOP→PWR_WAIT unconditionally. PWR_WAIT→ISSUE when the timer expires. ISSUE→GAP unconditionally. GAP→ISSUE on expiry while commands remain. GAP→TIM_FULL on expiry after the mode-register set. TIM_FULL→DONE. DONE is held until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards until `start` is seen, `cfg_wr`, `cmd_stb` and `done` stay low.
- R2: The cycle after `start` is sampled, the block writes the group 0 word to address 0, then the group 1 word to address 1 on the next cycle. No command is issued before both writes.
- R3: On the cycle after the group 1 write, the timing word is written to address 2 with its two refresh bits [REF_LSB+1:REF_LSB] forced to zero and all other bits unchanged.
- R4: On the cycle after that write, a NOP (code 0 in `cmd_word[1:0]`) is issued with the mode field `cmd_word[9:2]` equal to zero.
- R5: The precharge follows the NOP by exactly max(2, ceil(PWRUP_NS*CLK_MHZ/1000)) cycles.
- R6: After the wait, exactly ten commands are issued: one precharge (code 1), eight auto-refreshes (code 2) and one mode-register set (code 3), in that order.
- R7: Consecutive commands of that group of ten are exactly max(2, ceil(GAP_NS*CLK_MHZ/1000)) cycles apart.
- R8: With a zero override, the mode field of every precharge, refresh and mode-register set has one of four values. If timing bits [2:0] equal 2 it is 0x40, otherwise 0x60. If group 0 bit WIDTH_BIT is 1 (16-bit bus), that value is halved, giving 0x20 or 0x30.
- R9: A nonzero override is used unchanged as the mode field instead of the derived value.
- R10: One gap interval after the mode-register set, the full timing word is written to address 2. On the next cycle `done` rises.
- R11: Once `done` is high it stays high, no further write or command appears, and `start` is ignored until reset.
- R12: All configuration inputs and the override are captured when `start` is taken. Later changes to them have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the initialization run (taken in IDLE only) |
| tim_cfg | input | CFG_W | Timing configuration word (CAS latency, refresh field) |
| grp0_cfg | input | CFG_W | Bank-group 0 configuration word (width bit) |
| grp1_cfg | input | CFG_W | Bank-group 1 configuration word |
| mode_ovr | input | MODE_W | Mode-data override, zero means derive |
| cfg_wr | output | 1 | Configuration register write strobe |
| cfg_addr | output | 2 | Register select: 0 group 0, 1 group 1, 2 timing |
| cfg_data | output | CFG_W | Configuration write data |
| cmd_stb | output | 1 | SDRAM command strobe |
| cmd_word | output | MODE_W+2 | Mode field above a two-bit command code |
| done | output | 1 | Initialization finished |

## Verification
The bench builds the block with CLK_MHZ=100, GAP_NS=80 and PWRUP_NS=2000. This gives an 8-cycle command gap and a 200-cycle power-up wait, so the command spacing and the power-up distance can each be counted cycle-exactly across several complete runs. REF_LSB=12 and WIDTH_BIT=9 keep the refresh-clearing and width-halving paths in play. The stimulus covers the CAS latency field at values 2, 3, 7, and 2 with a neighbouring bit set, together with a width-bit neighbour, so that only the intended bits steer the mode value.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GRP0,
        ST_GRP1,
        ST_TIM_SAFE,
        ST_NOP,
        ST_PWR_WAIT,
        ST_ISSUE,
        ST_GAP,
        ST_TIM_FULL,
        ST_DONE
    } seq_state_t;

    // Two-bit SDRAM command codes carried in cmd_word[1:0]
    localparam logic [1:0] CMD_NOP = 2'd0;
    localparam logic [1:0] CMD_PRE = 2'd1;
    localparam logic [1:0] CMD_REF = 2'd2;
    localparam logic [1:0] CMD_MRS = 2'd3;

    // Configuration register selects
    localparam logic [1:0] CFG_GRP0 = 2'd0;
    localparam logic [1:0] CFG_GRP1 = 2'd1;
    localparam logic [1:0] CFG_TIM  = 2'd2;

    localparam int unsigned REF_BURST = 8;

    // Round a duration up to whole cycles, never below two
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdinit_mode.sv
module sdinit_mode #(
    parameter int CFG_W     = 32,
    parameter int MODE_W    = 8,
    parameter int WIDTH_BIT = 9
) (
    input  logic [CFG_W-1:0]  tim_cfg,
    input  logic [CFG_W-1:0]  grp0_cfg,
    input  logic [MODE_W-1:0] mode_ovr,
    output logic [MODE_W-1:0] mode_data
);

    localparam logic [MODE_W-1:0] MD_CL2 = MODE_W'(8'h40);
    localparam logic [MODE_W-1:0] MD_CL3 = MODE_W'(8'h60);

    logic [MODE_W-1:0] wide_val;
    logic              narrow_bus;

    always_comb begin
        wide_val   = (tim_cfg[2:0] == 3'd2) ? MD_CL2 : MD_CL3;
        narrow_bus = grp0_cfg[WIDTH_BIT];
        if (mode_ovr != '0)
            mode_data = mode_ovr;
        else if (narrow_bus)
            mode_data = wide_val >> 1;
        else
            mode_data = wide_val;
    end

endmodule

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
    import sdinit_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int MODE_W  = 8,
    parameter int REF_LSB = 12,
    parameter int PW_CYC  = 20000,
    parameter int GAP_CYC = 8,
    parameter int CNT_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  tim_in,
    input  logic [CFG_W-1:0]  grp0_in,
    input  logic [CFG_W-1:0]  grp1_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              ovr_zero_in,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cfg_wr,
    output logic [1:0]        cfg_addr,
    output logic [CFG_W-1:0]  cfg_data,
    output logic              cmd_stb,
    output logic [MODE_W+1:0] cmd_word,
    output logic              done
);

    localparam int          LAST_IDX = REF_BURST + 1;
    localparam int          IDX_W    = $clog2(LAST_IDX + 1);
    localparam int unsigned SAT_MAX  = max_u(PW_CYC, GAP_CYC);
    localparam logic [CFG_W-1:0] REF_MASK = ~(CFG_W'(3) << REF_LSB);

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CFG_W-1:0]  tim_q, grp0_q, grp1_q;
    logic [MODE_W-1:0] mode_q;
    logic              ovr_zero_q;
    logic [1:0]        issue_code;

    // State register and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            tim_q      <= '0;
            grp0_q     <= '0;
            grp1_q     <= '0;
            mode_q     <= '0;
            ovr_zero_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                tim_q      <= tim_in;
                grp0_q     <= grp0_in;
                grp1_q     <= grp1_in;
                mode_q     <= mode_in;
                ovr_zero_q <= ovr_zero_in;
            end
            if (state_q == ST_GAP && tmr_expired && idx_q != IDX_W'(LAST_IDX))
                idx_q <= idx_q + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_GRP0;
            ST_GRP0:     state_d = ST_GRP1;
            ST_GRP1:     state_d = ST_TIM_SAFE;
            ST_TIM_SAFE: state_d = ST_NOP;
            ST_NOP:      state_d = ST_PWR_WAIT;
            ST_PWR_WAIT: if (tmr_expired) state_d = ST_ISSUE;
            ST_ISSUE:    state_d = ST_GAP;
            ST_GAP:      if (tmr_expired)
                             state_d = (idx_q == IDX_W'(LAST_IDX)) ? ST_TIM_FULL : ST_ISSUE;
            ST_TIM_FULL: state_d = ST_DONE;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (idx_q == '0)
            issue_code = CMD_PRE;
        else if (idx_q == IDX_W'(LAST_IDX))
            issue_code = CMD_MRS;
        else
            issue_code = CMD_REF;
    end

    // Outputs
    always_comb begin
        cfg_wr   = 1'b0;
        cfg_addr = CFG_GRP0;
        cfg_data = '0;
        cmd_stb  = 1'b0;
        cmd_word = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PWR_WAIT, ST_GAP: ;
            ST_GRP0: begin
                cfg_wr   = 1'b1;
                cfg_addr = CFG_GRP0;
                cfg_data = grp0_q;
            end
            ST_GRP1: begin
                cfg_wr   = 1'b1;
                cfg_addr = CFG_GRP1;
                cfg_data = grp1_q;
            end
            ST_TIM_SAFE: begin
                cfg_wr   = 1'b1;
                cfg_addr = CFG_TIM;
                cfg_data = tim_q & REF_MASK;
            end
            ST_NOP: begin
                cmd_stb  = 1'b1;
                cmd_word = {{MODE_W{1'b0}}, CMD_NOP};
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PW_CYC - 2);
            end
            ST_ISSUE: begin
                cmd_stb  = 1'b1;
                cmd_word = {mode_q, issue_code};
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(GAP_CYC - 2);
            end
            ST_TIM_FULL: begin
                cfg_wr   = 1'b1;
                cfg_addr = CFG_TIM;
                cfg_data = tim_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // Cycles since the last command strobe, saturating
    logic [CNT_W-1:0] since_q;
    logic             seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cmd_stb) begin
            since_q <= CNT_W'(1);
            seen_q  <= 1'b1;
        end else if (since_q < CNT_W'(SAT_MAX)) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_WR_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cmd_stb)); // R2
    AST_NOP_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_word[1:0] == CMD_NOP) |-> cmd_word[MODE_W+1:2] == '0); // R4
    AST_PWRUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_word[1:0] == CMD_PRE) |-> (seen_q && since_q >= CNT_W'(PW_CYC))); // R5
    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && seen_q) |-> since_q >= CNT_W'(GAP_CYC)); // R7
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_word[1:0] != CMD_NOP && ovr_zero_q) |->
        (cmd_word[MODE_W+1:2] == MODE_W'(8'h40) || cmd_word[MODE_W+1:2] == MODE_W'(8'h60) ||
         cmd_word[MODE_W+1:2] == MODE_W'(8'h20) || cmd_word[MODE_W+1:2] == MODE_W'(8'h30))); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R11
    AST_QUIET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_stb && !cfg_wr)); // R11

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int MODE_W    = 8,
    parameter int WIDTH_BIT = 9,
    parameter int REF_LSB   = 12,
    parameter int CLK_MHZ   = 100,
    parameter int PWRUP_NS  = 200000,
    parameter int GAP_NS    = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  tim_cfg,
    input  logic [CFG_W-1:0]  grp0_cfg,
    input  logic [CFG_W-1:0]  grp1_cfg,
    input  logic [MODE_W-1:0] mode_ovr,
    output logic              cfg_wr,
    output logic [1:0]        cfg_addr,
    output logic [CFG_W-1:0]  cfg_data,
    output logic              cmd_stb,
    output logic [MODE_W+1:0] cmd_word,
    output logic              done
);

    localparam int PW_CYC  = int'(ns_to_cycles(PWRUP_NS, CLK_MHZ));
    localparam int GAP_CYC = int'(ns_to_cycles(GAP_NS, CLK_MHZ));
    localparam int CNT_W   = $clog2(int'(max_u(PW_CYC, GAP_CYC)) + 1);

    logic [MODE_W-1:0] mode_live;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;

    sdinit_mode #(
        .CFG_W     (CFG_W),
        .MODE_W    (MODE_W),
        .WIDTH_BIT (WIDTH_BIT)
    ) u_mode (
        .tim_cfg   (tim_cfg),
        .grp0_cfg  (grp0_cfg),
        .mode_ovr  (mode_ovr),
        .mode_data (mode_live)
    );

    sdinit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdinit_ctrl #(
        .CFG_W   (CFG_W),
        .MODE_W  (MODE_W),
        .REF_LSB (REF_LSB),
        .PW_CYC  (PW_CYC),
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tim_in      (tim_cfg),
        .grp0_in     (grp0_cfg),
        .grp1_in     (grp1_cfg),
        .mode_in     (mode_live),
        .ovr_zero_in (mode_ovr == '0),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_data    (cfg_data),
        .cmd_stb     (cmd_stb),
        .cmd_word    (cmd_word),
        .done        (done)
    );

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

    localparam int PW  = 200;  // 2000 ns at 100 MHz
    localparam int GAP = 8;    // 80 ns at 100 MHz
    localparam logic [31:0] REFCLR = ~(32'h3 << 12);

    // {timing, group0, override, expected mode}
    localparam logic [79:0] VECS [7] = '{
        {32'h0000_3002, 32'h0000_0000, 8'h00, 8'h40},
        {32'h0000_1003, 32'h0000_0000, 8'h00, 8'h60},
        {32'h0000_2002, 32'h0000_0200, 8'h00, 8'h20},
        {32'h0000_3003, 32'h0000_0201, 8'h00, 8'h30},
        {32'h0000_000A, 32'h0000_0400, 8'h00, 8'h40},
        {32'h0000_3007, 32'h0000_0200, 8'h00, 8'h30},
        {32'h0000_3002, 32'h0000_0000, 8'h5A, 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tim_cfg = '0, grp0_cfg = '0, grp1_cfg = '0;
    logic [7:0]  mode_ovr = '0;
    logic        cfg_wr, cmd_stb, done;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_data;
    logic [9:0]  cmd_word;

    sdram_init_seq #(
        .CLK_MHZ(100), .PWRUP_NS(2000), .GAP_NS(80), .REF_LSB(12), .WIDTH_BIT(9)
    ) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tim_cfg(tim_cfg),
        .grp0_cfg(grp0_cfg), .grp1_cfg(grp1_cfg), .mode_ovr(mode_ovr),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cmd_stb(cmd_stb), .cmd_word(cmd_word), .done(done)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_ev = 0, done_cyc = -1;
    bit log_en = 1'b0;
    logic [2:0]  ev_tag [0:31];
    logic [31:0] ev_dat [0:31];
    int          ev_cyc [0:31];

    // Event logger: write -> {0,addr}, command -> {1,code}
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (log_en) begin
            if (cfg_wr || cmd_stb) begin
                if (n_ev < 32) begin
                    ev_tag[n_ev] = cfg_wr ? {1'b0, cfg_addr} : {1'b1, cmd_word[1:0]};
                    ev_dat[n_ev] = cfg_wr ? cfg_data : {22'd0, cmd_word};
                    ev_cyc[n_ev] = cyc;
                end
                n_ev = n_ev + 1;
            end
            if (done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0;
        start = 1'b0;
        log_en = 1'b0;
        repeat (3) step();
        check(!cfg_wr && !cmd_stb && !done, "R1", "outputs in reset",
              {29'd0, cfg_wr, cmd_stb, done}, 32'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic run_vec(input logic [79:0] v, input logic [31:0] g1,
                           input bit scramble, input string mreq);
        logic [31:0] tim, g0, edat;
        logic [7:0]  expm;
        logic [2:0]  etag;
        logic [1:0]  code;
        int          erc;
        string       rt, rd, rc;
        tim  = v[79:48];
        g0   = v[47:16];
        expm = v[7:0];
        do_reset();
        tim_cfg  = tim;
        grp0_cfg = g0;
        grp1_cfg = g1;
        mode_ovr = v[15:8];
        n_ev = 0;
        done_cyc = -1;
        log_en = 1'b1;
        start = 1'b1;
        step();
        start = 1'b0;
        if (scramble) begin   // R12: inputs change after capture
            tim_cfg  = ~tim;
            grp0_cfg = g0 ^ 32'h0000_0200;
            grp1_cfg = ~g1;
            mode_ovr = 8'hC3;
        end
        for (int k = 0; k < 2000 && !done; k++) step();
        step();
        check(n_ev == 15, "R6", "event count", n_ev, 15);
        for (int i = 0; i < 15 && i < n_ev; i++) begin
            if (i < 3) begin
                etag = {1'b0, 2'(i)};
                edat = (i == 0) ? g0 : (i == 1) ? g1 : (tim & REFCLR);
                erc  = i;
                rt = "R2"; rd = (i == 2) ? "R3" : "R2"; rc = "R2";
            end else if (i == 3) begin
                etag = 3'b100;
                edat = 32'd0;
                erc  = 3;
                rt = "R4"; rd = "R4"; rc = "R4";
            end else if (i < 14) begin
                code = (i == 4) ? 2'd1 : (i == 13) ? 2'd3 : 2'd2;
                etag = {1'b1, code};
                edat = {22'd0, expm, code};
                erc  = 3 + PW + (i - 4) * GAP;
                rt = "R6"; rd = mreq; rc = (i == 4) ? "R5" : "R7";
            end else begin
                etag = 3'b010;
                edat = tim;
                erc  = 3 + PW + 10 * GAP;
                rt = "R10"; rd = scramble ? "R12" : "R10"; rc = "R10";
            end
            check(ev_tag[i] == etag, rt, $sformatf("event %0d kind", i), 32'(ev_tag[i]), 32'(etag));
            check(ev_dat[i] == edat, rd, $sformatf("event %0d data", i), ev_dat[i], edat);
            check(ev_cyc[i] - ev_cyc[0] == erc, rc, $sformatf("event %0d cycle", i),
                  ev_cyc[i] - ev_cyc[0], erc);
        end
        check(done_cyc - ev_cyc[0] == 4 + PW + 10 * GAP, "R10", "done rise cycle",
              done_cyc - ev_cyc[0], 4 + PW + 10 * GAP);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, then idle without start
        do_reset();
        log_en = 1'b1;
        n_ev = 0;
        repeat (20) step();
        check(n_ev == 0 && !done, "R1", "idle activity", n_ev, 0);

        // Vector table: R2..R10, R8 derivation, R9 override
        foreach (VECS[i]) begin
            run_vec(VECS[i], 32'hA5A5_0000 ^ 32'(i), 1'b0,
                    (VECS[i][15:8] != 8'h00) ? "R9" : "R8");
        end

        // R12: inputs changed right after start
        run_vec(VECS[0], 32'h1234_5678, 1'b1, "R12");

        // R11: done holds, start ignored, nothing further issued
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (40) step();
        check(n_ev == 15, "R11", "events after done", n_ev, 15);
        check(done == 1'b1, "R11", "done held", 32'(done), 1);

        // R1: reset clears done
        do_reset();
        check(done == 1'b0, "R1", "done after reset", 32'(done), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule